// File: doc/BRIEF.md
# Transmit Elastic Store with Selectable Depth

This block sits in an E1 transmit path between the system side and the line side. A serial bit stream arrives on the system clock and is written into a single-bit storage array. The same stream leaves on the transmit line clock. The array absorbs the wander between the two clocks. A two-bit size input either routes the stream around the array or picks one of three working depths: a one-frame depth, a two-frame depth or a short depth.

The write pointer crosses into the read domain as a Gray code. For depths that are not a power of two, it counts through a mirrored window of the full Gray sequence, so the wrap also changes a single bit. The read domain measures the fill level from the synchronized write pointer. When the fill level comes within a small guard distance of empty or of full, the read domain performs a slip. The slip moves the read pointer so that it lags the write pointer by half the selected depth, and the block reports the slip with a one-cycle pulse and a direction flag.

After reset, and after every change of the size input, both pointers restart at address zero. The output is held high until the write side has filled half of the array. Reading then starts with the separation already centred.

Top module: `tx_elastic_store`

## Requirements
- R1: `size_sel` selects the mode: 2'b00 bypass, 2'b01 a 256-bit store, 2'b10 a 512-bit store, 2'b11 a 92-bit store. In a storing mode the read address always stays below the selected depth.
- R2: In bypass mode, `ser_out` equals `ser_in` as sampled at the previous rising edge of `rd_clk`, and the array is not used.
- R3: While reset is asserted, and from the moment a new size takes effect until half the selected depth has been written, `ser_out` is 1 and `slip_pulse` is 0.
- R4: Once reading starts, the output stream is the input stream in order, delayed by about half the selected depth: 128, 256 or 46 bits, plus a few cycles of synchronizer latency.
- R5: When the synchronized fill level drops to 2 bits or fewer, a slip occurs with `slip_delete` = 0 (data is repeated), and the half-depth delay is restored.
- R6: When the synchronized fill level rises to the selected depth minus 2 or more, a slip occurs with `slip_delete` = 1 (data is discarded), and the half-depth delay is restored.
- R7: `slip_pulse` is high for exactly one `rd_clk` cycle per slip. `slip_delete` keeps the direction of the most recent slip.
- R8: Write and read addresses wrap at the selected depth. With equal clock rates, the stream stays continuous across many wraps and no slip occurs.
- R9: The write pointer reaches the read domain as a Gray code. It changes at most one bit per write cycle within a mode, including at the wrap in every depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | System-side clock; one bit is written per cycle |
| wr_rst_n | input | 1 | Asynchronous active-low reset of the write domain |
| rd_clk | input | 1 | Transmit line clock; one bit is read per cycle |
| rd_rst_n | input | 1 | Asynchronous active-low reset of the read domain |
| size_sel | input | 2 | Mode: 00 bypass, 01 256 bits, 10 512 bits, 11 92 bits; held quasi-static |
| ser_in | input | 1 | Serial data from the system side |
| ser_out | output | 1 | Serial data toward the line side, registered on rd_clk |
| slip_pulse | output | 1 | One-cycle pulse in the read domain when a slip occurs |
| slip_delete | output | 1 | Direction of the last slip: 0 repeat, 1 delete |

## Verification
The embedded properties check, on every cycle, the following:
- the single-bit Gray step of the write pointer, including at the mirrored wrap;
- the range of both addresses against the selected depth;
- the single-cycle slip pulse;
- the slip direction that each fill-level threshold must produce;
- the forced high output on the cycle after a size change.

Some behaviour only the scenarios can show. These are the real end-to-end delay of 128, 256 or 46 bits and the order of the data across many wraps. They also include the restored delay after a repeat slip and after a delete slip, which the bench drives by running the line clock one percent fast or slow, and the registered pass-through in bypass mode.

// File: rtl/es_pkg.sv
package es_pkg;

    typedef enum logic [1:0] {
        ES_BYPASS = 2'b00,
        ES_ONE    = 2'b01,
        ES_TWO    = 2'b10,
        ES_SHORT  = 2'b11
    } es_mode_e;

    // Working depth of a mode; bypass reports the full array size.
    function automatic int mode_depth(es_mode_e m, int d_one, int d_two, int d_short);
        case (m)
            ES_ONE:   return d_one;
            ES_SHORT: return d_short;
            default:  return d_two;
        endcase
    endfunction

    // Start of the mirrored Gray window used for a depth inside the full array.
    function automatic int gray_base(int full, int depth);
        return (full - depth) / 2;
    endfunction

endpackage

// File: rtl/es_sync2.sv
module es_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.s1 = d_i;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.s2;
endmodule

// File: rtl/es_wr_side.sv
module es_wr_side
    import es_pkg::*;
#(
    parameter int D_ONE   = 256,
    parameter int D_TWO   = 512,
    parameter int D_SHORT = 92,
    parameter int AW      = $clog2(D_TWO)
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic [1:0]       mode_i,
    input  logic             din_i,
    output logic [AW-1:0]    gray_o,
    output logic [D_TWO-1:0] mem_o
);
    typedef logic [AW-1:0] ptr_t;

    typedef struct packed {
        es_mode_e      mode;
        ptr_t          ptr;
        ptr_t          gray;
        logic [D_TWO-1:0] mem;
    } wr_state_t;

    function automatic ptr_t to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    wr_state_t s_d, s_q;
    logic [1:0] msync;
    es_mode_e   m_new;
    int         dep_w;
    int         nxt;

    es_sync2 #(.W(2)) u_mode_sync (
        .clk  (wr_clk),
        .rst_n(wr_rst_n),
        .d_i  (mode_i),
        .q_o  (msync)
    );

    always_comb begin
        s_d   = s_q;
        m_new = es_mode_e'(msync);
        dep_w = mode_depth(s_q.mode, D_ONE, D_TWO, D_SHORT);
        nxt   = int'(s_q.ptr) + 1;
        if (nxt >= dep_w) nxt = 0;
        if (m_new != s_q.mode) begin
            // restart at address zero of the new window
            s_d.mode = m_new;
            s_d.ptr  = '0;
            s_d.gray = to_gray(ptr_t'(gray_base(D_TWO,
                               mode_depth(m_new, D_ONE, D_TWO, D_SHORT))));
        end else if (s_q.mode != ES_BYPASS) begin
            s_d.mem[s_q.ptr] = din_i;
            s_d.ptr  = ptr_t'(nxt);
            s_d.gray = to_gray(ptr_t'(nxt + gray_base(D_TWO, dep_w)));
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            s_q.mode <= ES_BYPASS;
            s_q.ptr  <= '0;
            s_q.gray <= '0;
            s_q.mem  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign gray_o = s_q.gray;
    assign mem_o  = s_q.mem;

    // R9
    gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (s_q.mode == $past(s_q.mode)) |-> ($countones(s_q.gray ^ $past(s_q.gray)) <= 1));

    // R8
    wr_ptr_range_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (s_q.mode != ES_BYPASS) |-> (int'(s_q.ptr) < dep_w));
endmodule

// File: rtl/es_rd_side.sv
module es_rd_side
    import es_pkg::*;
#(
    parameter int D_ONE    = 256,
    parameter int D_TWO    = 512,
    parameter int D_SHORT  = 92,
    parameter int SLIP_GAP = 2,
    parameter int HOLD_WIN = 4,
    parameter int AW       = $clog2(D_TWO)
) (
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic [1:0]       mode_i,
    input  logic             din_i,
    input  logic [AW-1:0]    wgray_i,
    input  logic [D_TWO-1:0] mem_i,
    output logic             dout_o,
    output logic             slip_o,
    output logic             dir_o
);
    typedef logic [AW-1:0] ptr_t;

    typedef struct packed {
        es_mode_e mode;
        ptr_t     ptr;
        logic     hold;
        logic     arm;
        logic     dout;
        logic     slip;
        logic     dir;
    } rd_state_t;

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t b;
        b[AW-1] = g[AW-1];
        for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_state_t  s_d, s_q;
    logic [1:0] msync;
    ptr_t       wg_sync;
    es_mode_e   m_new;
    logic       chg_w;
    logic       active_w;
    int         dep_w, ctr, wbin_w, fill_w, back, inc;

    es_sync2 #(.W(2)) u_mode_sync (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .d_i  (mode_i),
        .q_o  (msync)
    );

    es_sync2 #(.W(AW)) u_ptr_sync (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .d_i  (wgray_i),
        .q_o  (wg_sync)
    );

    always_comb begin
        s_d      = s_q;
        s_d.slip = 1'b0;
        m_new    = es_mode_e'(msync);
        chg_w    = (m_new != s_q.mode);
        dep_w    = mode_depth(s_q.mode, D_ONE, D_TWO, D_SHORT);
        ctr      = dep_w / 2;
        wbin_w   = int'(gray2bin(wg_sync)) - gray_base(D_TWO, dep_w);
        fill_w   = wbin_w - int'(s_q.ptr);
        if (fill_w < 0) fill_w = fill_w + dep_w;
        back     = wbin_w - ctr;
        if (back < 0) back = back + dep_w;
        inc      = int'(s_q.ptr) + 1;
        if (inc >= dep_w) inc = 0;
        active_w = !chg_w && !s_q.hold && (s_q.mode != ES_BYPASS);

        if (chg_w) begin
            s_d.mode = m_new;
            s_d.ptr  = '0;
            s_d.hold = 1'b1;
            s_d.arm  = 1'b0;
            s_d.dout = 1'b1;
        end else if (s_q.mode == ES_BYPASS) begin
            s_d.dout = din_i;
            s_d.hold = 1'b1;
            s_d.arm  = 1'b0;
        end else if (s_q.hold) begin
            s_d.dout = 1'b1;
            if (wbin_w >= 0 && wbin_w <= HOLD_WIN) s_d.arm = 1'b1;
            if (s_q.arm && wbin_w >= ctr && wbin_w <= ctr + HOLD_WIN) s_d.hold = 1'b0;
        end else begin
            s_d.dout = mem_i[s_q.ptr];
            if (fill_w <= SLIP_GAP) begin
                s_d.slip = 1'b1;
                s_d.dir  = 1'b0;
                s_d.ptr  = ptr_t'(back);
            end else if (fill_w >= dep_w - SLIP_GAP) begin
                s_d.slip = 1'b1;
                s_d.dir  = 1'b1;
                s_d.ptr  = ptr_t'(back);
            end else begin
                s_d.ptr  = ptr_t'(inc);
            end
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            s_q.mode <= ES_BYPASS;
            s_q.ptr  <= '0;
            s_q.hold <= 1'b1;
            s_q.arm  <= 1'b0;
            s_q.dout <= 1'b1;
            s_q.slip <= 1'b0;
            s_q.dir  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout_o = s_q.dout;
    assign slip_o = s_q.slip;
    assign dir_o  = s_q.dir;

    // R1
    rd_ptr_range_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (s_q.mode != ES_BYPASS) |-> (int'(s_q.ptr) < dep_w));

    // R7
    slip_single_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        s_q.slip |=> !s_q.slip);

    // R5
    repeat_dir_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (active_w && fill_w <= SLIP_GAP) |=> (s_q.slip && !s_q.dir));

    // R6
    delete_dir_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (active_w && fill_w > SLIP_GAP && fill_w >= dep_w - SLIP_GAP) |=> (s_q.slip && s_q.dir));

    // R3
    hold_after_change_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        chg_w |=> (s_q.dout && !s_q.slip));
endmodule

// File: rtl/tx_elastic_store.sv
module tx_elastic_store #(
    parameter int D_ONE    = 256,
    parameter int D_TWO    = 512,
    parameter int D_SHORT  = 92,
    parameter int SLIP_GAP = 2,
    parameter int HOLD_WIN = 4
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    input  logic [1:0] size_sel,
    input  logic       ser_in,
    output logic       ser_out,
    output logic       slip_pulse,
    output logic       slip_delete
);
    // D_TWO must be a power of two and every depth even (mirrored Gray window).
    localparam int AW = $clog2(D_TWO);

    logic [AW-1:0]    wgray;
    logic [D_TWO-1:0] store;

    es_wr_side #(
        .D_ONE  (D_ONE),
        .D_TWO  (D_TWO),
        .D_SHORT(D_SHORT),
        .AW     (AW)
    ) u_wr (
        .wr_clk  (wr_clk),
        .wr_rst_n(wr_rst_n),
        .mode_i  (size_sel),
        .din_i   (ser_in),
        .gray_o  (wgray),
        .mem_o   (store)
    );

    es_rd_side #(
        .D_ONE   (D_ONE),
        .D_TWO   (D_TWO),
        .D_SHORT (D_SHORT),
        .SLIP_GAP(SLIP_GAP),
        .HOLD_WIN(HOLD_WIN),
        .AW      (AW)
    ) u_rd (
        .rd_clk  (rd_clk),
        .rd_rst_n(rd_rst_n),
        .mode_i  (size_sel),
        .din_i   (ser_in),
        .wgray_i (wgray),
        .mem_i   (store),
        .dout_o  (ser_out),
        .slip_o  (slip_pulse),
        .dir_o   (slip_delete)
    );
endmodule

// File: tb/tb_tx_elastic_store.sv
`timescale 1ns/1ps
module tb_tx_elastic_store;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       rst_n  = 1'b0;
    logic [1:0] size_sel = 2'b01;
    logic       patt_bit = 1'b0;
    logic       man_bit  = 1'b0;
    logic       manual   = 1'b0;
    logic       ser_in, ser_out, slip_pulse, slip_delete;
    realtime    rd_half = 5.0;
    int         wc = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    assign ser_in = manual ? man_bit : patt_bit;

    tx_elastic_store dut (
        .wr_clk     (wr_clk),
        .wr_rst_n   (rst_n),
        .rd_clk     (rd_clk),
        .rd_rst_n   (rst_n),
        .size_sel   (size_sel),
        .ser_in     (ser_in),
        .ser_out    (ser_out),
        .slip_pulse (slip_pulse),
        .slip_delete(slip_delete)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #(rd_half) rd_clk = ~rd_clk;
    end

    function automatic logic patt(int k);
        logic [31:0] h;
        h = k * 32'h9E3779B1;
        return h[16] ^ h[23] ^ h[29];
    endfunction

    always @(posedge wr_clk) wc <= wc + 1;
    always @(negedge wr_clk) patt_bit <= patt(wc);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd_cycles(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    // output held at 1 with no slip for len cycles after skip cycles
    task automatic check_ones(input string req, input int skip, input int len);
        int bad = 0;
        rd_cycles(skip);
        for (int i = 0; i < len; i++) begin
            @(negedge rd_clk);
            if (ser_out !== 1'b1) bad++;
            if (slip_pulse !== 1'b0) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    // capture 48 output bits and find the delay to the input stream
    task automatic check_sep(input string req, input int ctr);
        logic cap [48];
        int   wref;
        int   got = -1;
        @(negedge rd_clk);
        wref = wc;
        for (int i = 0; i < 48; i++) begin
            cap[i] = ser_out;
            if (i < 47) @(negedge rd_clk);
        end
        for (int s = ctr - 12; s <= ctr + 20 && got < 0; s++) begin
            bit ok = 1'b1;
            for (int i = 0; i < 48; i++)
                if (cap[i] !== patt(wref - s + i)) ok = 1'b0;
            if (ok) got = s;
        end
        check(got >= ctr - 1 && got <= ctr + 10, req, got, ctr);
    endtask

    task automatic wait_slip(input string req, input logic exp_dir);
        bit   seen = 1'b0;
        logic dir  = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge rd_clk);
            if (slip_pulse === 1'b1) begin
                seen = 1'b1;
                dir  = slip_delete;
            end
        end
        check(seen, req, int'(seen), 1);
        check(dir === exp_dir, req, int'(dir), int'(exp_dir));
        @(negedge rd_clk);
        // R7: pulse lasts one cycle, direction is kept
        check(slip_pulse === 1'b0 && slip_delete === exp_dir, "R7",
              int'(slip_pulse), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        rd_cycles(4);
        // R3: reset state
        check(ser_out === 1'b1 && slip_pulse === 1'b0, "R3 reset", int'(ser_out), 1);
        rst_n = 1'b1;
        check_ones("R3 after reset", 6, 100);
    endtask

    task automatic t_one_frame;
        rd_cycles(80);
        check_sep("R4 R1 mode 01", 128);
    endtask

    task automatic t_steady;
        int slips = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge rd_clk);
            if (slip_pulse === 1'b1) slips++;
        end
        check(slips == 0, "R8 no slip", slips, 0);
        check_sep("R8 wrap mode 01", 128);
    endtask

    task automatic t_two_frame;
        size_sel = 2'b10;
        rd_cycles(700);
        check_sep("R1 R8 mode 10", 256);
    endtask

    task automatic t_short;
        size_sel = 2'b11;
        check_ones("R3 size change", 6, 40);
        rd_cycles(100);
        check_sep("R4 R1 mode 11", 46);
    endtask

    task automatic t_underrun;
        rd_half = 4.95;
        wait_slip("R5", 1'b0);
        rd_cycles(6);
        check_sep("R5 R9 recentred", 46);
    endtask

    task automatic t_overrun;
        rd_half = 5.05;
        wait_slip("R6", 1'b1);
        rd_cycles(6);
        check_sep("R6 R9 recentred", 46);
        rd_half = 5.0;
    endtask

    task automatic t_bypass;
        int bad = 0;
        size_sel = 2'b00;
        manual   = 1'b1;
        rd_cycles(10);
        for (int i = 0; i < 16; i++) begin
            logic v;
            v = patt(i + 7) ^ i[0];
            @(negedge rd_clk);
            man_bit = v;
            @(negedge rd_clk);
            if (ser_out !== v) bad++;
        end
        check(bad == 0, "R2 bypass", bad, 0);
        manual = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog all requirements: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_one_frame();
        t_steady();
        t_two_frame();
        t_short();
        t_underrun();
        t_overrun();
        t_bypass();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule